// File: doc/BRIEF.md
# Divided-Clock Phase Error Detector with Pulse Timer

This block is the front end of an all-digital clock-recovery loop. It takes a recovered audio reference clock and a locally synthesized clock, and divides each one in its own domain by a programmable ratio down to a slow comparison rate. The divided waveforms are brought into a fast system-clock domain, where a two-flag phase-frequency detector compares their rising edges. The detector produces one error pulse, which lasts from the first edge to the second, and a sign output that says which input arrived first.

A timer in the system domain counts the cycles of each error pulse. When the pulse closes, the count and the sign are latched as one signed phase-error sample for a loop controller, which turns each sample into a new tuning word for the synthesizer. The sample stays valid until the controller acknowledges it. A sample that replaces an unacknowledged one raises an overrun flag.

A separate estimator counts divided reference edges over a fixed window of system cycles. This gives a coarse rate figure, so the synthesizer can be preset before fine locking starts.

Top module: `phase_err_front`

## Requirements
- R1: A divider programmed with value N toggles its divided output every N+1 cycles of its source clock, so the divided waveform rises once every 2(N+1) source cycles.
- R2: Each divided waveform passes through a two-flop synchronizer into the system domain. Each rising edge there yields exactly one one-cycle edge event, and both paths have equal latency.
- R3: The first edge event to arrive raises err_pulse in the next cycle. err_pulse falls once the other input's edge arrives. For an arrival gap of d system cycles, err_pulse stays high for exactly d cycles. While the pulse is high, err_sign is 1 when the reference led and 0 when the local clock led, and it does not change.
- R4: Edge events that arrive in the same cycle produce no error pulse. They still produce a sample with width 0 and smp_lead 0.
- R5: The width timer counts the cycles err_pulse is high. It saturates at all-ones (255 with CNT_W=8) and does not wrap.
- R6: When a pulse closes, smp_width and smp_lead (1 = reference led) are latched and smp_valid rises in the next cycle. smp_valid stays high until a cycle with smp_ack high, and falls after that cycle.
- R7: If a pulse closes while smp_valid is high and smp_ack is low, the new sample overwrites the old one and smp_overrun is set. smp_ack clears smp_overrun.
- R8: The estimator counts reference edge events over each window of GATE_CYC system cycles. It publishes the count on freq_est, with a one-cycle freq_upd pulse every GATE_CYC cycles.
- R9: While reset is held, err_pulse, err_sign, smp_valid, smp_width, smp_lead, smp_overrun, freq_est and freq_upd are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| ref_clk | input | 1 | Recovered reference clock |
| loc_clk | input | 1 | Locally synthesized clock |
| ref_div | input | DIV_W | Reference divide setting N (static while running) |
| loc_div | input | DIV_W | Local divide setting N (static while running) |
| smp_ack | input | 1 | Controller acknowledge of the held sample |
| err_pulse | output | 1 | Phase error pulse |
| err_sign | output | 1 | 1 when the reference edge came first |
| smp_valid | output | 1 | A captured sample is waiting |
| smp_width | output | CNT_W | Captured error width in system cycles |
| smp_lead | output | 1 | Captured sign, 1 = reference led |
| smp_overrun | output | 1 | A sample was overwritten before acknowledge |
| freq_est | output | EST_W | Reference edges counted in the last window |
| freq_upd | output | 1 | One-cycle strobe when freq_est is refreshed |

## Verification
The bench sweeps the edge offset cycle by cycle with both the reference and the local clock leading. It checks the captured width, the sign and the measured pulse length, so a detector with an off-by-one timer, or with its sign taken from the wrong flag, is caught at once. Coincident edges are checked for a zero-width sample with no pulse; a design that skipped them or timed one stray cycle would report a nonzero width. Offsets beyond the counter range check that the width sticks at 255 and does not wrap to a small number. A missed acknowledge checks that the overrun flag is raised and that the newest sample is kept. The rate estimate is checked at two divide settings, and the refresh spacing is checked as well, which catches a gate counter that is off by one cycle.

// File: rtl/pef_pkg.sv
package pef_pkg;

  typedef enum logic {
    LEAD_LOC = 1'b0,
    LEAD_REF = 1'b1
  } lead_e;

endpackage

// File: rtl/pef_rst_sync.sv
module pef_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 1'b0;
      srst_n  <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      srst_n  <= stage_q;
    end
  end

endmodule

// File: rtl/pef_clk_div.sv
module pef_clk_div #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg,
  output logic             lvl
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             lvl_q, lvl_d;
  logic             tick;

  always_comb begin
    tick  = (cnt_q == cfg);
    cnt_d = tick ? '0 : cnt_q + DIV_W'(1);
    lvl_d = tick ? ~lvl_q : lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign lvl = lvl_q;

  AST_DIV_TOGGLE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != cfg) && $stable(cfg) |=> $stable(lvl_q)); // R1

endmodule

// File: rtl/pef_sync_edge.sv
module pef_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic async_lvl,
  output logic rise
);

  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= async_lvl;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise = sync_q & ~prev_q;

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R2

endmodule

// File: rtl/pef_detector.sv
module pef_detector #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_edge,
  input  logic             loc_edge,
  input  logic             ack,
  output logic             err_pulse,
  output logic             err_sign,
  output logic             smp_valid,
  output logic [CNT_W-1:0] smp_width,
  output logic             smp_lead,
  output logic             smp_overrun
);
  import pef_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             flag_ref_q, flag_ref_d;
  logic             flag_loc_q, flag_loc_d;
  lead_e            pol_q, pol_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic [CNT_W-1:0] width_q, width_d;
  logic             lead_q, lead_d;
  logic             valid_q, valid_d;
  logic             ovr_q, ovr_d;
  logic             ref_set, loc_set, close, err, cap_en;

  // next-state logic
  always_comb begin
    ref_set    = flag_ref_q | ref_edge;
    loc_set    = flag_loc_q | loc_edge;
    close      = ref_set & loc_set;
    flag_ref_d = ref_set & ~close;
    flag_loc_d = loc_set & ~close;
    err        = flag_ref_q | flag_loc_q;

    pol_d = pol_q;
    if (!err) begin
      if (ref_edge && !loc_edge)      pol_d = LEAD_REF;
      else if (loc_edge && !ref_edge) pol_d = LEAD_LOC;
    end

    cnt_inc = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + CNT_W'(1);
    cnt_d   = err ? cnt_inc : '0;

    cap_en  = close;
    width_d = err ? cnt_inc : '0;
    lead_d  = flag_ref_q;

    if (close)    valid_d = 1'b1;
    else if (ack) valid_d = 1'b0;
    else          valid_d = valid_q;

    if (close && valid_q && !ack) ovr_d = 1'b1;
    else if (ack)                 ovr_d = 1'b0;
    else                          ovr_d = ovr_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_ref_q <= 1'b0;
      flag_loc_q <= 1'b0;
      pol_q      <= LEAD_LOC;
      cnt_q      <= '0;
      width_q    <= '0;
      lead_q     <= 1'b0;
      valid_q    <= 1'b0;
      ovr_q      <= 1'b0;
    end else begin
      flag_ref_q <= flag_ref_d;
      flag_loc_q <= flag_loc_d;
      pol_q      <= pol_d;
      cnt_q      <= cnt_d;
      valid_q    <= valid_d;
      ovr_q      <= ovr_d;
      if (cap_en) begin
        width_q <= width_d;
        lead_q  <= lead_d;
      end
    end
  end

  assign err_pulse   = err;
  assign err_sign    = pol_q;
  assign smp_valid   = valid_q;
  assign smp_width   = width_q;
  assign smp_lead    = lead_q;
  assign smp_overrun = ovr_q;

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_ref_q && flag_loc_q)); // R3
  AST_SIGN_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse && $past(err_pulse) |-> $stable(err_sign)); // R3
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX) && err |=> (cnt_q == CNT_MAX)); // R5
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && !ack |=> smp_valid); // R6
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    close && smp_valid && !ack |=> smp_overrun); // R7

endmodule

// File: rtl/pef_freq_est.sv
module pef_freq_est #(
  parameter int GATE_CYC = 1000000,
  parameter int EST_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_edge,
  output logic [EST_W-1:0] est,
  output logic             upd
);

  localparam int              GW     = $clog2(GATE_CYC);
  localparam logic [GW-1:0]   G_LAST = GW'(GATE_CYC - 1);
  localparam logic [EST_W-1:0] E_MAX = '1;

  logic [GW-1:0]    gate_q, gate_d;
  logic [EST_W-1:0] acc_q, acc_d, acc_inc;
  logic [EST_W-1:0] est_q;
  logic             upd_q, gate_end;

  always_comb begin
    gate_end = (gate_q == G_LAST);
    gate_d   = gate_end ? '0 : gate_q + GW'(1);
    acc_inc  = (acc_q == E_MAX) ? E_MAX : acc_q + EST_W'(ref_edge);
    acc_d    = gate_end ? '0 : acc_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= '0;
      acc_q  <= '0;
      est_q  <= '0;
      upd_q  <= 1'b0;
    end else begin
      gate_q <= gate_d;
      acc_q  <= acc_d;
      upd_q  <= gate_end;
      if (gate_end) est_q <= acc_inc;
    end
  end

  assign est = est_q;
  assign upd = upd_q;

  AST_UPD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> !upd); // R8
  AST_EST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |-> $stable(est)); // R8

endmodule

// File: rtl/phase_err_front.sv
module phase_err_front #(
  parameter int DIV_W    = 16,
  parameter int CNT_W    = 16,
  parameter int EST_W    = 16,
  parameter int GATE_CYC = 1000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_clk,
  input  logic             loc_clk,
  input  logic [DIV_W-1:0] ref_div,
  input  logic [DIV_W-1:0] loc_div,
  input  logic             smp_ack,
  output logic             err_pulse,
  output logic             err_sign,
  output logic             smp_valid,
  output logic [CNT_W-1:0] smp_width,
  output logic             smp_lead,
  output logic             smp_overrun,
  output logic [EST_W-1:0] freq_est,
  output logic             freq_upd
);

  logic sys_rst_n, ref_rst_n, loc_rst_n;
  logic ref_lvl, loc_lvl;
  logic ref_rise, loc_rise;

  pef_rst_sync u_rst_sys (.clk(clk),     .arst_n(rst_n), .srst_n(sys_rst_n));
  pef_rst_sync u_rst_ref (.clk(ref_clk), .arst_n(rst_n), .srst_n(ref_rst_n));
  pef_rst_sync u_rst_loc (.clk(loc_clk), .arst_n(rst_n), .srst_n(loc_rst_n));

  pef_clk_div #(.DIV_W(DIV_W)) u_div_ref (
    .clk(ref_clk), .rst_n(ref_rst_n), .cfg(ref_div), .lvl(ref_lvl));
  pef_clk_div #(.DIV_W(DIV_W)) u_div_loc (
    .clk(loc_clk), .rst_n(loc_rst_n), .cfg(loc_div), .lvl(loc_lvl));

  pef_sync_edge u_sync_ref (
    .clk(clk), .rst_n(sys_rst_n), .async_lvl(ref_lvl), .rise(ref_rise));
  pef_sync_edge u_sync_loc (
    .clk(clk), .rst_n(sys_rst_n), .async_lvl(loc_lvl), .rise(loc_rise));

  pef_detector #(.CNT_W(CNT_W)) u_det (
    .clk(clk), .rst_n(sys_rst_n),
    .ref_edge(ref_rise), .loc_edge(loc_rise), .ack(smp_ack),
    .err_pulse(err_pulse), .err_sign(err_sign),
    .smp_valid(smp_valid), .smp_width(smp_width),
    .smp_lead(smp_lead), .smp_overrun(smp_overrun));

  pef_freq_est #(.GATE_CYC(GATE_CYC), .EST_W(EST_W)) u_est (
    .clk(clk), .rst_n(sys_rst_n), .ref_edge(ref_rise),
    .est(freq_est), .upd(freq_upd));

endmodule

// File: tb/tb_phase_err_front.sv
`timescale 1ns/1ps
module tb_phase_err_front;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_clk = 1'b0, loc_clk = 1'b0;
  logic       ref_run = 1'b0, loc_run = 1'b0;
  logic [7:0] ref_div = 8'd4, loc_div = 8'd4;
  logic       smp_ack = 1'b0;
  logic       err_pulse, err_sign, smp_valid, smp_lead, smp_overrun, freq_upd;
  logic [7:0] smp_width, freq_est;

  int checks = 0, fails = 0, cyc = 0;
  int run_len = 0, last_len = 0;
  logic first_sign = 1'b0;

  phase_err_front #(.DIV_W(8), .CNT_W(8), .EST_W(8), .GATE_CYC(400)) dut (
    .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .loc_clk(loc_clk),
    .ref_div(ref_div), .loc_div(loc_div), .smp_ack(smp_ack),
    .err_pulse(err_pulse), .err_sign(err_sign), .smp_valid(smp_valid),
    .smp_width(smp_width), .smp_lead(smp_lead), .smp_overrun(smp_overrun),
    .freq_est(freq_est), .freq_upd(freq_upd));

  always #5 clk = ~clk;

  always begin
    if (ref_run) #20 ref_clk = ~ref_clk;
    else begin ref_clk = 1'b0; wait (ref_run); end
  end
  always begin
    if (loc_run) #20 loc_clk = ~loc_clk;
    else begin loc_clk = 1'b0; wait (loc_run); end
  end

  // pulse length monitor
  always @(negedge clk) begin
    if (err_pulse) begin
      if (run_len == 0) first_sign = err_sign;
      run_len = run_len + 1;
    end else if (run_len != 0) begin
      last_len = run_len;
      run_len = 0;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 150000) begin
      checks = checks + 1;
      fails = fails + 1;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start_run(input int k, input bit ref_first, input int div);
    ref_run = 1'b0; loc_run = 1'b0; smp_ack = 1'b0;
    #100;
    @(negedge clk); rst_n = 1'b0; ref_div = 8'(div); loc_div = 8'(div);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    last_len = 0; run_len = 0;
    if (ref_first) begin ref_run = 1'b1; #(k * 10); loc_run = 1'b1; end
    else begin loc_run = 1'b1; #(k * 10); ref_run = 1'b1; end
  endtask

  task automatic get_sample(output int w, output bit lead, output int ln, output bit sg);
    @(negedge clk);
    while (!smp_valid) @(negedge clk);
    w = int'(smp_width); lead = smp_lead;
    #1 ln = last_len; sg = first_sign;
    smp_ack = 1'b1;
    @(negedge clk);
    smp_ack = 1'b0;
  endtask

  task automatic wait_upd();
    @(negedge clk);
    while (!freq_upd) @(negedge clk);
  endtask

  initial begin
    int w, ln, gap;
    bit lead, sg;

    // R9: reset state
    repeat (3) @(negedge clk);
    chk(err_pulse == 0 && err_sign == 0, "R9 error outputs in reset", int'(err_pulse), 0);
    chk(smp_valid == 0 && smp_overrun == 0 && smp_lead == 0, "R9 sample flags in reset", int'(smp_valid), 0);
    chk(smp_width == 0, "R9 width in reset", int'(smp_width), 0);
    chk(freq_est == 0 && freq_upd == 0, "R9 estimate in reset", int'(freq_est), 0);

    // R3 R4 R6 R2: offset sweep, both leads
    for (int k = 0; k < 12; k++) begin
      for (int dir = 0; dir < 2; dir++) begin
        if (k == 0 && dir == 1) continue;
        start_run(k, dir == 0, 4);
        for (int s = 0; s < 2; s++) begin
          get_sample(w, lead, ln, sg);
          chk(w == k, (k == 0) ? "R4 coincident width" : "R3 captured width", w, k);
          chk(lead == (k != 0 && dir == 0), "R6 captured lead", int'(lead), int'(k != 0 && dir == 0));
          chk(ln == k, (k == 0) ? "R4 no pulse on coincidence" : "R3 pulse length", ln, k);
          if (k != 0) chk(sg == (dir == 0), "R3 sign during pulse", int'(sg), int'(dir == 0));
          chk(smp_valid == 0, "R6 ack clears valid", int'(smp_valid), 0);
        end
      end
    end

    // R5: saturation and a large in-range width
    start_run(200, 1'b1, 40);
    get_sample(w, lead, ln, sg);
    chk(w == 200, "R5 large width below limit", w, 200);
    start_run(300, 1'b1, 40);
    get_sample(w, lead, ln, sg);
    chk(w == 255, "R5 width saturates", w, 255);
    chk(ln == 300, "R5 pulse itself not limited", ln, 300);
    chk(lead == 1, "R5 lead at saturation", int'(lead), 1);

    // R6 R7: hold without ack, overrun, ack clears
    start_run(5, 1'b0, 4);
    @(negedge clk);
    while (!smp_valid) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(smp_valid == 1 && smp_overrun == 0, "R6 valid held without ack", int'(smp_valid), 1);
    repeat (40) @(negedge clk);
    chk(smp_overrun == 1, "R7 overrun set", int'(smp_overrun), 1);
    chk(smp_valid == 1 && smp_width == 5 && smp_lead == 0, "R7 newest sample kept", int'(smp_width), 5);
    smp_ack = 1'b1;
    @(negedge clk);
    smp_ack = 1'b0;
    chk(smp_overrun == 0 && smp_valid == 0, "R7 ack clears overrun", int'(smp_overrun), 0);

    // R8 R1: rate estimate at two divide settings
    start_run(0, 1'b1, 4);
    repeat (3) wait_upd();
    chk(freq_est == 10, "R8 R1 estimate div 4", int'(freq_est), 10);
    gap = 0;
    @(negedge clk);
    while (!freq_upd) begin gap++; @(negedge clk); end
    chk(gap + 1 == 400, "R8 refresh spacing", gap + 1, 400);
    chk(freq_est == 10, "R8 estimate repeats", int'(freq_est), 10);
    start_run(0, 1'b1, 9);
    repeat (3) wait_upd();
    chk(freq_est == 5, "R8 R1 estimate div 9", int'(freq_est), 5);

    summary();
    $finish;
  end

endmodule